// File: doc/BRIEF.md
# Spectrum Magnitude Reorder and Rescale Stage

This stage sits behind an FFT engine and its magnitude unit. It receives one single-precision (IEEE 754, 32-bit) magnitude per valid strobe. The results arrive in bit-reversed bin order. Each value is brought back to the signal's original amplitude range by a power-of-two gain. The gain is applied by adding to the exponent field alone, so no floating-point multiplier is needed. The first arrival is the DC bin, and it gets one extra doubling.

Each rescaled word is written into a frame buffer. Its address is the arrival count with its bits mirrored, so the buffer ends up holding the frame in natural bin order. Once the last sample of the frame is in, the buffer is drained in ascending address order. The drain writes one word per clock through a FIFO-style write port with a write strobe.

A small task controller frames the whole operation. It leaves idle on a start pulse and reports done together with the final write. It then falls back to idle, ready for the next frame.

Top module: `spec_mag_reorder`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to the idle state (`task_state` = 2'b00) with `out_wr` low and `out_mag` zero. The reset is synchronous and active high.
- R2: A `start` pulse seen in idle moves `task_state` to running (2'b01) on the next clock. A `start` seen while running has no effect on the state or on the data.
- R3: For every bin other than the first arrival, a word with a nonzero exponent (bits 30:23) leaves with that exponent plus 4. The sign (bit 31) and the mantissa (bits 22:0) are unchanged.
- R4: The first arrival of a frame is the DC bin. If its exponent is nonzero, the exponent is raised by 5 and the sign and mantissa are kept.
- R5: A word whose exponent field is zero is stored and emitted bit for bit unchanged, whatever bin it belongs to.
- R6: The arrival with count n (0 to 1023) is stored at the 10-bit mirror of n, where bit i of n becomes bit 9−i of the address. The drain therefore emits, as its k-th word, the arrival whose count is the mirror of k.
- R7: After the 1024th accepted valid, the drain emits exactly 1024 words. It does so on consecutive clocks, with `out_wr` high for one cycle per word, in ascending address order.
- R8: `task_state` shows done (2'b10) in the same cycle as the final drain strobe. It holds done for exactly one cycle and is then back in idle.
- R9: `in_valid` is ignored in idle, during the drain and in done. No such word is stored, and none advances the arrival count.
- R10: The arrival count restarts at 0 for every frame, so the first accepted word after each start is treated as the DC bin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Task start pulse, acted on in idle |
| in_valid | input | 1 | Magnitude word present on `in_mag` |
| in_mag | input | 32 | Single-precision magnitude, bit-reversed bin order |
| task_state | output | 2 | 00 idle, 01 running, 10 done |
| out_wr | output | 1 | Write strobe of the output port |
| out_mag | output | 32 | Rescaled magnitude, natural bin order |

## Verification
Two events coincide at the end of a frame: the final drain strobe and the done report. The scoreboard checks, on the very pop of word 1023, that `task_state` already reads done. It then checks that the next cycle is idle.

Arrivals and drain writes can also meet in one cycle. The bench holds `in_valid` high with junk data through part of the drain, while writes are streaming out. Any such word that reached the buffer would corrupt a later pop. Any such word that advanced the count would shift the DC bin of the next frame, which the following frame's comparison would expose.

// File: rtl/spec_mag_pkg.sv
package spec_mag_pkg;

    localparam int FP_W     = 32;
    localparam int EXP_W    = 8;
    localparam int MANT_W   = 23;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [MANT_W-1:0] mant;
    } fp_word_t;

    typedef enum logic [1:0] {
        TS_IDLE = 2'b00,
        TS_RUN  = 2'b01,
        TS_DONE = 2'b10
    } task_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_FILL,
        SQ_DRAIN,
        SQ_DONE
    } seq_state_e;

    function automatic fp_word_t exp_gain(input fp_word_t w, input logic [EXP_W-1:0] add);
        fp_word_t r;
        r = w;
        if (w.expo != '0)
            r.expo = w.expo + add;
        return r;
    endfunction

    function automatic task_state_e seq_to_task(input seq_state_e s);
        case (s)
            SQ_FILL, SQ_DRAIN: return TS_RUN;
            SQ_DONE:           return TS_DONE;
            default:           return TS_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/mag_exp_scaler.sv
module mag_exp_scaler
    import spec_mag_pkg::*;
#(
    parameter int BASE_SHIFT = 4,
    parameter int DC_EXTRA   = 1
) (
    input  fp_word_t raw,
    input  logic     is_dc,
    output fp_word_t scaled
);
    localparam logic [EXP_W-1:0] ADD_BIN = EXP_W'(BASE_SHIFT);
    localparam logic [EXP_W-1:0] ADD_DC  = EXP_W'(BASE_SHIFT + DC_EXTRA);

    always_comb begin
        scaled = exp_gain(raw, is_dc ? ADD_DC : ADD_BIN);
    end
endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
    import spec_mag_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              in_valid,
    output seq_state_e        state,
    output logic [ADDR_W-1:0] fill_cnt,
    output logic [ADDR_W-1:0] drain_cnt,
    output logic              accept,
    output logic              drain_rd
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    assign accept   = (state == SQ_FILL) && in_valid;
    assign drain_rd = (state == SQ_DRAIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            fill_cnt  <= '0;
            drain_cnt <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    fill_cnt  <= '0;
                    drain_cnt <= '0;
                    if (start) state <= SQ_FILL;
                end
                SQ_FILL: begin
                    if (in_valid) begin
                        fill_cnt <= fill_cnt + 1'b1;
                        if (fill_cnt == LAST) state <= SQ_DRAIN;
                    end
                end
                SQ_DRAIN: begin
                    drain_cnt <= drain_cnt + 1'b1;
                    if (drain_cnt == LAST) state <= SQ_DONE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/reorder_ram.sv
module reorder_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/spec_mag_reorder.sv
module spec_mag_reorder
    import spec_mag_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int BASE_SHIFT = 4,
    parameter int DC_EXTRA   = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        in_valid,
    input  logic [31:0] in_mag,
    output logic [1:0]  task_state,
    output logic        out_wr,
    output logic [31:0] out_mag
);
    seq_state_e        seq_state;
    logic [ADDR_W-1:0] fill_cnt;
    logic [ADDR_W-1:0] drain_cnt;
    logic [ADDR_W-1:0] mirror_addr;
    logic              accept;
    logic              drain_rd;
    fp_word_t          scaled;

    frame_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .in_valid  (in_valid),
        .state     (seq_state),
        .fill_cnt  (fill_cnt),
        .drain_cnt (drain_cnt),
        .accept    (accept),
        .drain_rd  (drain_rd)
    );

    for (genvar b = 0; b < ADDR_W; b++) begin : g_mirror
        assign mirror_addr[b] = fill_cnt[ADDR_W-1-b];
    end

    mag_exp_scaler #(.BASE_SHIFT(BASE_SHIFT), .DC_EXTRA(DC_EXTRA)) u_scale (
        .raw    (fp_word_t'(in_mag)),
        .is_dc  (fill_cnt == '0),
        .scaled (scaled)
    );

    reorder_ram #(.ADDR_W(ADDR_W), .DATA_W(FP_W)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (accept),
        .waddr (mirror_addr),
        .wdata (scaled),
        .re    (drain_rd),
        .raddr (drain_cnt),
        .rdata (out_mag)
    );

    always_ff @(posedge clk) begin
        if (rst) out_wr <= 1'b0;
        else     out_wr <= drain_rd;
    end

    assign task_state = seq_to_task(seq_state);
endmodule

// File: rtl/spec_mag_reorder_chk.sv
module spec_mag_reorder_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic [1:0] task_state,
    input logic       out_wr
);
    // R2: a start seen in idle brings the task to running
    p_start_runs_r2: assert property (@(posedge clk) disable iff (rst)
        (task_state == 2'b00 && start) |=> task_state == 2'b01);

    // R2: from idle the task never jumps straight to done
    p_no_skip_r2: assert property (@(posedge clk) disable iff (rst)
        (task_state == 2'b00) |=> task_state != 2'b10);

    // R7: every write strobe follows a running cycle
    p_strobe_after_run_r7: assert property (@(posedge clk) disable iff (rst)
        out_wr |-> $past(task_state) == 2'b01);

    // R8: done coincides with a write strobe
    p_done_with_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        (task_state == 2'b10) |-> out_wr);

    // R8: done lasts one cycle
    p_done_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        (task_state == 2'b10) |=> task_state == 2'b00);

    // R9: no write strobe while idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (task_state == 2'b00) |-> !out_wr);
endmodule

bind spec_mag_reorder spec_mag_reorder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .task_state (task_state),
    .out_wr     (out_wr)
);

// File: tb/spec_mag_reorder_bench.sv
module spec_mag_reorder_bench;
    localparam int N = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_mag = '0;
    logic [1:0]  task_state;
    logic        out_wr;
    logic [31:0] out_mag;

    int nchecks = 0;
    int nfail   = 0;
    bit idle_next = 1'b0;

    logic [31:0] exp_q[$];
    int          idx_q[$];
    logic [31:0] in_vals [N];

    always #10 clk = ~clk;

    spec_mag_reorder u_spec_mag_reorder (
        .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
        .in_mag(in_mag), .task_state(task_state), .out_wr(out_wr), .out_mag(out_mag)
    );

    function automatic int mirror10(input int v);
        int r = 0;
        for (int b = 0; b < 10; b++) if (v[b]) r |= (1 << (9 - b));
        return r;
    endfunction

    function automatic logic [31:0] mkval(input int f, input int i);
        logic [31:0] w;
        w[31]    = i[0] ^ f[0];
        w[30:23] = (((i * 7 + f) % 41) == 3) ? 8'd0 : 8'(60 + ((i + f * 13) % 90));
        w[22:0]  = 23'(i * 2654435 + f * 977);
        if (f == 2 && i == 0) w[30:23] = 8'd0;
        return w;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (idle_next) begin
                check(task_state == 2'b00, "R8 idle after done", 32'(task_state), 32'd0);
                idle_next = 1'b0;
            end
            if (out_wr) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected write", out_mag, 32'd0);
                end else begin
                    logic [31:0] e;
                    int k;
                    e = exp_q.pop_front();
                    k = idx_q.pop_front();
                    if (e[30:23] == 8'd0)  check(out_mag === e, "R5 zero exponent kept", out_mag, e);
                    else if (k == 0)       check(out_mag === e, "R4 DC bin", out_mag, e);
                    else                   check(out_mag === e, "R3 R6 R7 bin word", out_mag, e);
                    if (k == N - 1) begin
                        check(task_state == 2'b10, "R8 done with last write", 32'(task_state), 32'd2);
                        idle_next = 1'b1;
                    end
                end
            end
        end
    end

    task automatic run_frame(input int f, input bit gaps, input bit poke_start);
        for (int i = 0; i < N; i++) in_vals[i] = mkval(f, i);
        for (int k = 0; k < N; k++) begin
            logic [31:0] w;
            w = in_vals[mirror10(k)];
            if (w[30:23] != 8'd0) w[30:23] = w[30:23] + ((k == 0) ? 8'd5 : 8'd4);
            exp_q.push_back(w);
            idx_q.push_back(k);
        end
        @(posedge clk); #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        check(task_state == 2'b01, "R2 running after start", 32'(task_state), 32'd1);
        for (int i = 0; i < N; i++) begin
            in_valid = 1'b1;
            in_mag   = in_vals[i];
            start    = (poke_start && i == 500);
            @(posedge clk); #2;
            start = 1'b0;
            if (poke_start && i == 500)
                check(task_state == 2'b01, "R2 start ignored while running", 32'(task_state), 32'd1);
            if (gaps && (i % 3 == 1)) begin
                in_valid = 1'b0;
                in_mag   = 32'hDEAD_BEEF;
                @(posedge clk); #2;
            end
        end
        // R9: junk during the drain
        in_mag = 32'h4040_0000;
        for (int j = 0; j < 60; j++) begin
            @(posedge clk); #2;
        end
        in_valid = 1'b0;
        while (task_state != 2'b00) @(negedge clk);
        // R9 R10: junk while idle must not shift the next frame
        @(posedge clk); #2;
        in_valid = 1'b1;
        in_mag   = 32'h3F80_0000;
        for (int j = 0; j < 5; j++) begin
            @(posedge clk); #2;
        end
        in_valid = 1'b0;
        @(negedge clk);
        check(exp_q.size() == 0, "R7 all 1024 words emitted", 32'(exp_q.size()), 32'd0);
    endtask

    initial begin : watchdog
        for (int c = 0; c < 150000; c++) @(posedge clk);
        nchecks++;
        nfail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchecks, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        @(negedge clk);
        check(task_state == 2'b00, "R1 reset state", 32'(task_state), 32'd0);
        check(out_wr == 1'b0, "R1 reset strobe", 32'(out_wr), 32'd0);
        check(out_mag == 32'd0, "R1 reset data", out_mag, 32'd0);
        @(posedge clk); #2 rst = 1'b0;
        // R9: valid in idle before any start
        in_valid = 1'b1;
        in_mag   = 32'h4100_0000;
        repeat (4) @(posedge clk);
        #2 in_valid = 1'b0;
        run_frame(0, 1'b0, 1'b0);
        run_frame(1, 1'b1, 1'b1);
        run_frame(2, 1'b0, 1'b0);   // R10 and R5: DC with zero exponent
        // R1: reset in the middle of a fill
        @(posedge clk); #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0; in_valid = 1'b1; in_mag = 32'h4000_0000;
        repeat (10) @(posedge clk);
        #2 rst = 1'b1; in_valid = 1'b0;
        @(posedge clk); #2 rst = 1'b0;
        @(negedge clk);
        check(task_state == 2'b00, "R1 reset mid-frame", 32'(task_state), 32'd0);
        run_frame(3, 1'b0, 1'b0);   // R10: fresh count after reset
        $display("== %0d vectors applied, %0d miscompares ==", nchecks, nfail);
        $finish;
    end
endmodule